// File: doc/BRIEF.md
# Triggered Fan Tachometer Counter

This block measures fan speed on one of up to sixteen tachometer inputs at a time. Software starts a measurement by raising one channel's trigger bit. The block then counts prescaled clock ticks across one full fan revolution and reports the count in a single shared result word. A fan gives two tach pulses per revolution, so a revolution spans two rising-edge intervals. Software turns the count into RPM.

Each channel has an enable bit and a 3-bit code that names the PWM output driving that fan. The code arrives as a 2-bit low part and a 1-bit high part from separate fields. The block captures the code of the channel being measured so that software can read it with the result. Tach inputs are asynchronous to the clock. They pass through a two-flop synchronizer before rising-edge detection. If a fan is stopped, a timeout ends the measurement with a valid count of zero.

Top module: `fan_tach_meter`

## Requirements
- R1: After synchronous reset, `result_word` is all zeros and `busy` is low.
- R2: A measurement starts on a 0-to-1 transition of a `trig` bit whose `chan_en` bit is set. The start clears the done flag and the count, and raises `busy`, all visible one cycle after the clock edge that sees the transition.
- R3: A rising `trig` bit on a channel whose enable bit is clear starts nothing. `busy` stays low and `result_word` keeps its previous value.
- R4: When several trigger bits rise in the same cycle, the lowest-index enabled channel among them is measured.
- R5: The tick divider is `4 << (2*div_code)`: code 0 gives 4 cycles, 1 gives 16, 2 gives 64 and 3 gives 256.
- R6: The count is the number of ticks from the first detected rising edge to the third, which is one revolution. It is reported in `result_word[19:0]`. Bit 31 is the done flag and bits 30:20 read zero.
- R7: If no full revolution is seen within 2**TMO_W ticks of the start, the measurement ends with done set and a count of zero. This is a valid result meaning a stopped fan.
- R8: Tach edges are counted only after a two-flop synchronizer, followed by a rising-edge detector on the synchronized signal.
- R9: `meas_src` equals `{src_hi[ch], src_lo[2*ch+1:2*ch]}` for the measured channel `ch`. It is captured at start and held while the measurement runs.
- R10: `busy` is high from start until the result is posted, and `busy` and the done flag are never high together.
- R11: Once posted, `result_word` holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tach_in | input | NCH | Raw asynchronous tach inputs |
| chan_en | input | NCH | Per-channel enable |
| trig | input | NCH | Trigger bits; a rising bit requests a measurement |
| div_code | input | CODE_W | Tick divider code |
| src_lo | input | 2*NCH | Low two bits of each channel's source code, channel i at [2i+1:2i] |
| src_hi | input | NCH | High bit of each channel's source code |
| result_word | output | 32 | Bit 31 done, bits 19:0 count, others zero |
| busy | output | 1 | Measurement in progress |
| meas_src | output | 3 | Source code of the measured channel |

## Verification
The assertions assume that `chan_en`, `div_code` and the source fields stay still while a measurement runs. They also assume that software drops the trigger register to zero before setting a new bit, so each request shows up as one clean rising edge. The stimulus follows both rules: it changes configuration only between measurements and writes zero for a cycle before every trigger. The tach waveforms have periods that are exact multiples of the divider, so the count of ticks over two intervals is exact whatever the prescaler phase.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

    localparam int CNT_W    = 20;
    localparam int WORD_W   = 32;
    localparam int SRC_W    = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_FIRST,
        ST_SPAN_A,
        ST_SPAN_B
    } meas_state_e;

    typedef struct packed {
        logic             done;
        logic [CNT_W-1:0] count;
    } tach_result_t;

    function automatic logic [WORD_W-1:0] pack_word(input tach_result_t r);
        logic [WORD_W-1:0] w;
        w = '0;
        w[WORD_W-1]  = r.done;
        w[CNT_W-1:0] = r.count;
        return w;
    endfunction

endpackage

// File: rtl/tach_sync.sv
module tach_sync #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] raw,
    output logic [NCH-1:0] rise
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic s1, s2, s3;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
                s3 <= 1'b0;
            end else begin
                s1 <= raw[i];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign rise[i] = s2 & ~s3;
    end
endmodule

// File: rtl/tach_trig_sel.sv
module tach_trig_sel #(
    parameter int NCH   = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   trig,
    input  logic [NCH-1:0]   en,
    output logic             start,
    output logic [IDX_W-1:0] sel
);
    logic [NCH-1:0] trig_q;
    logic [NCH-1:0] cand;

    always_ff @(posedge clk) begin
        if (rst) trig_q <= '0;
        else     trig_q <= trig;
    end

    assign cand  = trig & ~trig_q & en;
    assign start = |cand;

    // lowest index wins: scan downward so the last hit is the smallest
    always_comb begin
        sel = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (cand[i]) sel = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tach_prescaler.sv
module tach_prescaler #(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int PRE_W = 3 + 2 * ((1 << CODE_W) - 1);

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] limit;

    assign limit = (PRE_W'(4) << {code, 1'b0}) - PRE_W'(1);
    assign tick  = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || clr || !run)  cnt_q <= '0;
        else if (cnt_q == limit) cnt_q <= '0;
        else                     cnt_q <= cnt_q + PRE_W'(1);
    end
endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter
    import fan_tach_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int CODE_W = 2,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    tach_in,
    input  logic [NCH-1:0]    chan_en,
    input  logic [NCH-1:0]    trig,
    input  logic [CODE_W-1:0] div_code,
    input  logic [2*NCH-1:0]  src_lo,
    input  logic [NCH-1:0]    src_hi,
    output logic [31:0]       result_word,
    output logic              busy,
    output logic [2:0]        meas_src
);
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic [NCH-1:0]   rise_vec;
    logic             start;
    logic [IDX_W-1:0] sel;
    logic             tick;

    meas_state_e      state_q;
    logic [IDX_W-1:0] ch_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic [TMO_W-1:0] tmo_q;
    tach_result_t     res_q;
    logic [SRC_W-1:0] src_q;
    logic             edge_now;
    logic             counting;

    tach_sync #(.NCH(NCH)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  (tach_in),
        .rise (rise_vec)
    );

    tach_trig_sel #(.NCH(NCH), .IDX_W(IDX_W)) u_trig (
        .clk   (clk),
        .rst   (rst),
        .trig  (trig),
        .en    (chan_en),
        .start (start),
        .sel   (sel)
    );

    tach_prescaler #(.CODE_W(CODE_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (start),
        .run  (busy),
        .code (div_code),
        .tick (tick)
    );

    assign busy     = (state_q != ST_IDLE);
    assign edge_now = rise_vec[ch_q];
    assign counting = (state_q == ST_SPAN_A) || (state_q == ST_SPAN_B);
    assign cnt_next = cnt_q + CNT_W'(tick && counting && (cnt_q != '1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ch_q    <= '0;
            cnt_q   <= '0;
            tmo_q   <= '0;
            res_q   <= '0;
            src_q   <= '0;
        end else if (start) begin
            state_q <= ST_WAIT_FIRST;
            ch_q    <= sel;
            cnt_q   <= '0;
            tmo_q   <= '0;
            res_q   <= '0;
            src_q   <= {src_hi[sel], src_lo[{sel, 1'b0} +: 2]};
        end else if (busy) begin
            if ((state_q == ST_SPAN_B) && edge_now) begin
                state_q     <= ST_IDLE;
                res_q.done  <= 1'b1;
                res_q.count <= cnt_next;
            end else if (tick && (tmo_q == '1)) begin
                state_q     <= ST_IDLE;
                res_q.done  <= 1'b1;
                res_q.count <= '0;
            end else begin
                tmo_q <= tmo_q + TMO_W'(tick);
                cnt_q <= cnt_next;
                if (edge_now) begin
                    case (state_q)
                        ST_WAIT_FIRST: state_q <= ST_SPAN_A;
                        ST_SPAN_A:     state_q <= ST_SPAN_B;
                        default:       state_q <= state_q;
                    endcase
                end
            end
        end
    end

    assign result_word = pack_word(res_q);
    assign meas_src    = src_q;
endmodule

// File: rtl/fan_tach_meter_chk.sv
module fan_tach_meter_chk #(
    parameter int NCH   = 16,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [IDX_W-1:0] sel,
    input logic [NCH-1:0]   chan_en,
    input logic             busy,
    input logic [31:0]      result_word,
    input logic [2:0]       meas_src
);
    AST_START_ENABLED: assert property (@(posedge clk) disable iff (rst)
        start |-> chan_en[sel]);                                   // R3
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start |=> (!result_word[31] && busy));                     // R2
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy && result_word[31]));                               // R10
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(result_word));               // R11
    AST_SRC_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && !start) |=> $stable(meas_src));                   // R9
endmodule

bind fan_tach_meter fan_tach_meter_chk #(.NCH(NCH), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .sel         (sel),
    .chan_en     (chan_en),
    .busy        (busy),
    .result_word (result_word),
    .meas_src    (meas_src)
);

// File: tb/fan_tach_meter_tb.sv
module fan_tach_meter_tb;
    localparam int NCH    = 16;
    localparam int CODE_W = 2;
    localparam int TMO_W  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NCH-1:0]    tach_in = '0;
    logic [NCH-1:0]    chan_en = '0;
    logic [NCH-1:0]    trig = '0;
    logic [CODE_W-1:0] div_code = '0;
    logic [2*NCH-1:0]  src_lo;
    logic [NCH-1:0]    src_hi;
    logic [31:0]       result_word;
    logic              busy;
    logic [2:0]        meas_src;

    typedef struct {
        int    cnt;
        int    src;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   per [NCH];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_err = 0;
    logic prev_done = 1'b0;

    fan_tach_meter #(.NCH(NCH), .CODE_W(CODE_W), .TMO_W(TMO_W)) u_dut (
        .clk(clk), .rst(rst), .tach_in(tach_in), .chan_en(chan_en),
        .trig(trig), .div_code(div_code), .src_lo(src_lo), .src_hi(src_hi),
        .result_word(result_word), .busy(busy), .meas_src(meas_src)
    );

    always #5 clk = ~clk;

    function automatic int src_of(int ch);
        return 7 - (ch % 8);
    endfunction

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            src_lo[2*i +: 2] = 2'(src_of(i));
            src_hi[i]        = 1'(src_of(i) >> 2);
        end
    end

    always @(negedge clk) begin
        cyc = cyc + 1;
        for (int i = 0; i < NCH; i++)
            tach_in[i] = (per[i] != 0) && ((cyc % per[i]) < per[i] / 2);
    end

    task automatic chk(input bit ok, input string msg, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", msg, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    // monitor: pops the expected item whenever a result is posted
    always @(negedge clk) begin
        if (!rst && result_word[31] && !prev_done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11 unexpected result posted", int'(result_word[19:0]), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(int'(result_word[19:0]) == e.cnt, {e.tag, " count"},
                    int'(result_word[19:0]), e.cnt);
                chk(int'(meas_src) == e.src, {e.tag, " R9 source code"},
                    int'(meas_src), e.src);
                chk(result_word[30:20] == 11'd0, {e.tag, " R6 upper bits zero"},
                    int'(result_word[30:20]), 0);
            end
        end
        prev_done = result_word[31];
    end

    task automatic measure(input logic [NCH-1:0] mask, input int code, input int ecnt,
                           input int esrc, input string tag);
        exp_t e;
        int   n;
        @(negedge clk);
        trig     = '0;
        div_code = CODE_W'(code);
        @(negedge clk);
        e.cnt = ecnt; e.src = esrc; e.tag = tag;
        exp_q.push_back(e);
        trig = mask;
        @(negedge clk);
        chk(!result_word[31] && busy, {tag, " R2 start clears done, raises busy"},
            int'({result_word[31], busy}), 1);
        n = 0;
        while (!result_word[31] && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 5000) chk(1'b0, {tag, " R10 result never posted"}, n, 5000);
        @(negedge clk);
        chk(!busy, {tag, " R10 busy low after result"}, int'(busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 150000);
        finish_run();
    end

    initial begin
        for (int i = 0; i < NCH; i++) per[i] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(result_word == 32'd0 && !busy, "R1 reset state", int'(result_word), 0);

        // R5 R6 R8: div 4, period 40 -> 2*40/4 = 20
        per[3] = 40; chan_en[3] = 1'b1;
        measure(NCH'(1) << 3, 0, 20, src_of(3), "R6 R8 ch3 div4");
        // R5: div 16, period 128 -> 16
        per[5] = 128; chan_en[5] = 1'b1;
        measure(NCH'(1) << 5, 1, 16, src_of(5), "R5 ch5 div16");
        // R5: div 64, period 256 -> 8
        per[0] = 256; chan_en[0] = 1'b1;
        measure(NCH'(1) << 0, 2, 8, src_of(0), "R5 ch0 div64");

        // R3: disabled channel with a running fan is ignored
        per[9] = 40; chan_en[9] = 1'b0;
        @(negedge clk); trig = '0;
        @(negedge clk); trig = NCH'(1) << 9;
        repeat (300) @(negedge clk);
        chk(result_word == {1'b1, 11'd0, 20'd8} && !busy,
            "R3 disabled trigger ignored", int'(result_word[19:0]), 8);

        // R5: div 256, period 512 -> 4
        per[10] = 512; chan_en[10] = 1'b1;
        measure(NCH'(1) << 10, 3, 4, src_of(10), "R5 ch10 div256");

        // R4: ch2 and ch6 both rise, ch2 enabled -> ch2 (period 40 -> 20)
        per[2] = 40; chan_en[2] = 1'b1;
        per[6] = 80; chan_en[6] = 1'b1;
        measure((NCH'(1) << 2) | (NCH'(1) << 6), 0, 20, src_of(2), "R4 lowest wins");
        // R4: ch1 disabled and ch6 enabled rise together -> ch6 (period 80 -> 40)
        per[1] = 40; chan_en[1] = 1'b0;
        measure((NCH'(1) << 1) | (NCH'(1) << 6), 0, 40, src_of(6), "R4 skip disabled");

        // R7: stopped fan -> timeout, valid zero
        per[7] = 0; chan_en[7] = 1'b1;
        measure(NCH'(1) << 7, 0, 0, src_of(7), "R7 stopped fan timeout");

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R11 all expected results seen", exp_q.size(), 0);
        finish_run();
    end
endmodule